// File: doc/BRIEF.md
# Program Counter Sequencer with Hardware Repeat Loop

This block owns the program counter of a simple in-order core and works out, once per retired instruction, where fetch goes next. It supports a zero-overhead repeat loop: a start address and an end address, supplied from outside, bound the loop body, while a count register and a repeat-active status bit, both held here, control how often the body runs. The block also owns the status word. A debugger breakpoint on one instruction address, and entry to an external interrupt at fixed vectors, are built on top of normal sequencing.

Execution units report what each retiring instruction did: a taken branch and its target, and any write the instruction makes to the count or the status word. The block merges these writes with its own repeat bookkeeping. It then chooses the next PC and, when needed, saves copies of PC and status for the debug or interrupt handler. When an interrupt is taken, a stack-swap request is raised because supervisor mode changes.

Top module: `pc_seq`

## Requirements
- R1: Reset (rst_n low at a clock edge) sets pc to RESET_VEC and clears the count, the status word, the debug and backup copies, the stack-swap request and any pending interrupt.
- R2: In a cycle with step high and no branch, no loop-back and no trap, pc advances by 8. In a cycle with step low and no interrupt accepted, pc, count and status hold.
- R3: A taken branch (br_valid) sets pc to br_target. This holds even when the loop would otherwise jump back.
- R4: When pc equals rpt_end and the count is nonzero or the registered repeat-active bit (status bit 5) is set, the count is decremented by one before execution. A count of 0 wraps to all ones. A count write from the instruction itself (ex_cnt_we) replaces the result of the decrement.
- R5: Whether the loop jumps back depends on a sample of the count taken before execution. The instruction's own count write does not change that sample.
- R6: The repeat-active bit, after the instruction's status write, is cleared when it is set, pc equals rpt_end and the resulting count is 0.
- R7: When the repeat-active bit after the instruction's status write is set, the pre-execution count was nonzero, pc equals rpt_end and no branch is taken, pc goes to rpt_start.
- R8: When pc equals brk_addr and debug-enable (status bit 2, after the instruction's write) is set, a trap is taken. dbg_pc gets the PC that was chosen, dbg_status gets the status word with bit 1 set, the status word becomes bit 0 kept plus bit 3 set with all other bits cleared, and pc goes to DBG_VEC.
- R9: An interrupt request with interrupt-enable (status bit 4) set is accepted in that cycle. bkp_pc and bkp_status get the current pc and status, the status word is cleared, pc goes to IRQ_VEC, and the instruction stepping in that cycle is discarded along with its count and status writes.
- R10: A request that arrives while interrupt-enable is clear is held pending and accepted in the first cycle in which the bit is set. Any further requests that arrive while one is pending are merged into it, so only one entry results.
- R11: sp_swap is high for exactly the one cycle that follows each accepted interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | An instruction retires this cycle |
| br_valid | input | 1 | The retiring instruction takes a branch |
| br_target | input | ADDR_W | Branch target |
| ex_cnt_we | input | 1 | The instruction writes the repeat count |
| ex_cnt | input | CNT_W | Value of that count write |
| ex_st_we | input | 1 | The instruction writes the status word |
| ex_st | input | STAT_W | Value of that status write |
| rpt_start | input | ADDR_W | First address of the loop body |
| rpt_end | input | ADDR_W | Last address of the loop body |
| brk_addr | input | ADDR_W | Debugger breakpoint address |
| irq_req | input | 1 | External interrupt request pulse |
| pc | output | ADDR_W | Program counter |
| rpt_cnt | output | CNT_W | Repeat count |
| status | output | STAT_W | Status word |
| dbg_pc | output | ADDR_W | PC saved by a debug trap |
| dbg_status | output | STAT_W | Status saved by a debug trap |
| bkp_pc | output | ADDR_W | PC saved on interrupt entry |
| bkp_status | output | STAT_W | Status saved on interrupt entry |
| sp_swap | output | 1 | Stack-swap request after interrupt entry |

## Verification
A two-pass loop with a count of 2 is run three times round. This shows the difference between the decrement, the loop-back and the repeat-active clear on the final pass, and a plain fall-through after the loop ends. Rows at the loop end separate the pre-execution sample from the instruction's own writes: a count of 0 with the bit set wraps without looping back, and a count write of 0 still loops back and clears the bit. A branch taken at the loop end proves that branches win. Directed cases trigger the breakpoint and reach the interrupt in both ways, enabled at once or through a masked pending request, to separate the saved copies, the discarded step and the merging of duplicate requests.

// File: rtl/pc_seq_pkg.sv
// Shared status-word layout for the PC sequencer.
// Assumes an 8-bit status word; bits 6 and 7 are general flags passed through.
package pc_seq_pkg;
    localparam int STAT_W = 8;
    localparam int SB_SM  = 0;  // supervisor mode
    localparam int SB_EA  = 1;  // exception-active marker set by a debug trap
    localparam int SB_DB  = 2;  // debug breakpoint enable
    localparam int SB_DS  = 3;  // in debug handler
    localparam int SB_IE  = 4;  // interrupt enable
    localparam int SB_RP  = 5;  // repeat loop active
endpackage

// File: rtl/pc_seq_repeat.sv
// Repeat-loop arithmetic for one retiring instruction.
// Samples the count before execution, applies the end-of-body decrement,
// lets the instruction's own count write win, and decides loop-back and
// clearing of the repeat-active bit. Purely combinational.
module pc_seq_repeat #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] rpt_end,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              rp_pre,
    input  logic              rp_post,
    input  logic              ex_cnt_we,
    input  logic [CNT_W-1:0]  ex_cnt,
    output logic [CNT_W-1:0]  cnt_next,
    output logic              loop_take,
    output logic              rp_clear
);
    logic at_end;
    logic pre_nz;
    logic [CNT_W-1:0] cnt_mid;

    // Pre-execution sample, decrement, then the instruction's own write.
    always_comb begin
        at_end   = (pc == rpt_end);
        pre_nz   = (cnt_q != '0);
        cnt_mid  = (at_end && (pre_nz || rp_pre)) ? cnt_q - CNT_W'(1) : cnt_q;
        cnt_next = ex_cnt_we ? ex_cnt : cnt_mid;
    end

    // Loop-back and repeat-active clear decisions.
    always_comb begin
        loop_take = rp_post && pre_nz && at_end;
        rp_clear  = rp_post && at_end && (cnt_next == '0);
    end
endmodule

// File: rtl/pc_seq_select.sv
// Next-PC priority and debug breakpoint trap.
// Chooses branch target, then loop start, then PC+8; a breakpoint hit
// on the current address then saves that choice and redirects to the
// debug vector. Purely combinational.
module pc_seq_select
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] DBG_VEC = 32'hFFFF_F128
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              loop_take,
    input  logic [ADDR_W-1:0] rpt_start,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [STAT_W-1:0] st_post,
    output logic [ADDR_W-1:0] pc_pick,
    output logic              dbg_take,
    output logic [ADDR_W-1:0] pc_next,
    output logic [STAT_W-1:0] st_next,
    output logic [STAT_W-1:0] dbg_st
);
    localparam logic [STAT_W-1:0] SM_MASK = STAT_W'(1) << SB_SM;
    localparam logic [STAT_W-1:0] DS_MASK = STAT_W'(1) << SB_DS;
    localparam logic [STAT_W-1:0] EA_MASK = STAT_W'(1) << SB_EA;

    // Fixed priority for the sequential next PC.
    always_comb begin
        if (br_valid)       pc_pick = br_target;
        else if (loop_take) pc_pick = rpt_start;
        else                pc_pick = pc + ADDR_W'(8);
    end

    // Breakpoint trap overrides the chosen PC and rewrites status.
    always_comb begin
        dbg_take = (pc == brk_addr) && st_post[SB_DB];
        dbg_st   = st_post | EA_MASK;
        st_next  = dbg_take ? ((st_post & SM_MASK) | DS_MASK) : st_post;
        pc_next  = dbg_take ? DBG_VEC : pc_pick;
    end
endmodule

// File: rtl/pc_seq_irq.sv
// Single-entry external interrupt gate.
// Accepts a live request (new or pending) when enabled; otherwise holds
// one pending request; extra requests while pending are merged.
module pc_seq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic ie,
    output logic accept,
    output logic pending_q
);
    logic irq_live;

    // Acceptance of a new or held request.
    always_comb begin
        irq_live = irq_req || pending_q;
        accept   = irq_live && ie;
    end

    // Pending flag: set when masked, cleared on acceptance or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                pending_q <= 1'b0;
        else if (accept)           pending_q <= 1'b0;
        else if (irq_live && !ie)  pending_q <= 1'b1;
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !ie) |=> pending_q); // R10
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !pending_q); // R10
endmodule

// File: rtl/pc_seq.sv
// PC sequencer top: holds PC, repeat count, status word and the saved
// debug/interrupt copies. One instruction retires per cycle with step
// high; an accepted interrupt takes the cycle and discards that step.
// Assumes rpt_start, rpt_end and brk_addr are held stable by their owner.
module pc_seq
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    parameter logic [ADDR_W-1:0] DBG_VEC   = 32'hFFFF_F128,
    parameter logic [ADDR_W-1:0] IRQ_VEC   = 32'hFFFF_F138
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              ex_cnt_we,
    input  logic [CNT_W-1:0]  ex_cnt,
    input  logic              ex_st_we,
    input  logic [STAT_W-1:0] ex_st,
    input  logic [ADDR_W-1:0] rpt_start,
    input  logic [ADDR_W-1:0] rpt_end,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic              irq_req,
    output logic [ADDR_W-1:0] pc,
    output logic [CNT_W-1:0]  rpt_cnt,
    output logic [STAT_W-1:0] status,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [STAT_W-1:0] dbg_status,
    output logic [ADDR_W-1:0] bkp_pc,
    output logic [STAT_W-1:0] bkp_status,
    output logic              sp_swap
);
    localparam logic [STAT_W-1:0] RP_MASK = STAT_W'(1) << SB_RP;

    logic [ADDR_W-1:0] pc_q, dpc_q, bpc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [STAT_W-1:0] st_q, dst_q, bst_q;
    logic              swap_q;

    logic [STAT_W-1:0] st_exec, st_post, st_next, dbg_st;
    logic [CNT_W-1:0]  cnt_next;
    logic [ADDR_W-1:0] pc_pick, pc_next;
    logic              loop_take, rp_clear, dbg_take, accept, pending_q;

    // Status after the instruction's own write and the repeat-active clear.
    always_comb begin
        st_exec = ex_st_we ? ex_st : st_q;
        st_post = rp_clear ? (st_exec & ~RP_MASK) : st_exec;
    end

    pc_seq_repeat #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rpt (
        .pc(pc_q), .rpt_end(rpt_end), .cnt_q(cnt_q),
        .rp_pre(st_q[SB_RP]), .rp_post(st_exec[SB_RP]),
        .ex_cnt_we(ex_cnt_we), .ex_cnt(ex_cnt),
        .cnt_next(cnt_next), .loop_take(loop_take), .rp_clear(rp_clear)
    );

    pc_seq_select #(.ADDR_W(ADDR_W), .DBG_VEC(DBG_VEC)) u_sel (
        .pc(pc_q), .br_valid(br_valid), .br_target(br_target),
        .loop_take(loop_take), .rpt_start(rpt_start), .brk_addr(brk_addr),
        .st_post(st_post), .pc_pick(pc_pick), .dbg_take(dbg_take),
        .pc_next(pc_next), .st_next(st_next), .dbg_st(dbg_st)
    );

    pc_seq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ie(st_q[SB_IE]),
        .accept(accept), .pending_q(pending_q)
    );

    // Architectural state update: interrupt entry first, else one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_VEC;
            cnt_q  <= '0;
            st_q   <= '0;
            dpc_q  <= '0;
            dst_q  <= '0;
            bpc_q  <= '0;
            bst_q  <= '0;
            swap_q <= 1'b0;
        end else begin
            swap_q <= accept;
            if (accept) begin
                bpc_q <= pc_q;
                bst_q <= st_q;
                st_q  <= '0;
                pc_q  <= IRQ_VEC;
            end else if (step) begin
                pc_q  <= pc_next;
                cnt_q <= cnt_next;
                st_q  <= st_next;
                if (dbg_take) begin
                    dpc_q <= pc_pick;
                    dst_q <= dbg_st;
                end
            end
        end
    end

    assign pc         = pc_q;
    assign rpt_cnt    = cnt_q;
    assign status     = st_q;
    assign dbg_pc     = dpc_q;
    assign dbg_status = dst_q;
    assign bkp_pc     = bpc_q;
    assign bkp_status = bst_q;
    assign sp_swap    = swap_q;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pc_q == RESET_VEC && cnt_q == '0 && st_q == '0)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !accept) |=> ($stable(pc_q) && $stable(cnt_q) && $stable(st_q))); // R2
    AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !accept && br_valid && !dbg_take) |=> (pc_q == $past(br_target))); // R3
    AST_LOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !accept && !br_valid && loop_take && !dbg_take) |=> (pc_q == $past(rpt_start))); // R7
    AST_DBG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !accept && dbg_take) |=> (pc_q == DBG_VEC && st_q[SB_DS] && dst_q[SB_EA])); // R8
    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pc_q == IRQ_VEC && st_q == '0 && bpc_q == $past(pc_q))); // R9
    AST_SWAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> sp_swap); // R11
endmodule

// File: tb/pc_seq_test.sv
// Self-checking bench for pc_seq: a table of loop-sequencing steps, then
// directed tests for breakpoint, interrupt entry, masking and reset.
module pc_seq_test;
    import pc_seq_pkg::*;

    localparam int CLK_P = 10;
    localparam logic [31:0] DBGV = 32'hFFFF_F128;
    localparam logic [31:0] IRQV = 32'hFFFF_F138;

    typedef struct packed {
        logic        stp;
        logic        brv;
        logic [31:0] brt;
        logic        cwe;
        logic [15:0] cv;
        logic        swe;
        logic [7:0]  sv;
        logic [31:0] epc;
        logic [15:0] ecnt;
        logic [7:0]  est;
    } vec_t;

    // Loop body 0x100..0x110; status bit 5 = repeat active.
    localparam vec_t TBL [0:19] = '{
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h008,16'h0000,8'h00}, // R2 sequential
        '{1'b1,1'b1,32'h100,1'b1,16'h2,1'b1,8'h20, 32'h100,16'h0002,8'h20}, // R3 branch, loop setup
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h108,16'h0002,8'h20}, // R2
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h110,16'h0002,8'h20}, // R2
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h100,16'h0001,8'h20}, // R4 R7 decrement and loop
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h108,16'h0001,8'h20}, // R2
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h110,16'h0001,8'h20}, // R2
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h100,16'h0000,8'h00}, // R6 R7 last loop-back clears bit
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h108,16'h0000,8'h00}, // R2
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h110,16'h0000,8'h00}, // R2
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h118,16'h0000,8'h00}, // R4 no decrement when idle
        '{1'b0,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h118,16'h0000,8'h00}, // R2 hold
        '{1'b1,1'b1,32'h110,1'b0,16'h0,1'b1,8'h20, 32'h110,16'h0000,8'h20}, // R3
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h118,16'hFFFF,8'h20}, // R4 wrap, R5 no loop
        '{1'b1,1'b1,32'h110,1'b0,16'h0,1'b0,8'h00, 32'h110,16'hFFFF,8'h20}, // R3
        '{1'b1,1'b0,32'h0,  1'b1,16'h0,1'b0,8'h00, 32'h100,16'h0000,8'h00}, // R5 own write, R6 clear
        '{1'b1,1'b1,32'h110,1'b1,16'h3,1'b1,8'h20, 32'h110,16'h0003,8'h20}, // R3
        '{1'b1,1'b1,32'h200,1'b0,16'h0,1'b0,8'h00, 32'h200,16'h0002,8'h20}, // R3 branch beats loop, R4
        '{1'b1,1'b1,32'h110,1'b0,16'h0,1'b0,8'h00, 32'h110,16'h0002,8'h20}, // R3
        '{1'b1,1'b0,32'h0,  1'b0,16'h0,1'b0,8'h00, 32'h100,16'h0001,8'h20}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0, br_valid = 1'b0, ex_cnt_we = 1'b0, ex_st_we = 1'b0, irq_req = 1'b0;
    logic [31:0] br_target = '0, rpt_start = 32'h100, rpt_end = 32'h110, brk_addr = 32'hFFFF_0000;
    logic [15:0] ex_cnt = '0;
    logic [7:0]  ex_st = '0;
    logic [31:0] pc, dbg_pc, bkp_pc;
    logic [15:0] rpt_cnt;
    logic [7:0]  status, dbg_status, bkp_status;
    logic        sp_swap;

    int n_chk = 0;
    int n_fail = 0;

    pc_seq uut (
        .clk(clk), .rst_n(rst_n), .step(step), .br_valid(br_valid),
        .br_target(br_target), .ex_cnt_we(ex_cnt_we), .ex_cnt(ex_cnt),
        .ex_st_we(ex_st_we), .ex_st(ex_st), .rpt_start(rpt_start),
        .rpt_end(rpt_end), .brk_addr(brk_addr), .irq_req(irq_req),
        .pc(pc), .rpt_cnt(rpt_cnt), .status(status), .dbg_pc(dbg_pc),
        .dbg_status(dbg_status), .bkp_pc(bkp_pc), .bkp_status(bkp_status),
        .sp_swap(sp_swap)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic bv, input logic [31:0] bt,
                         input logic cw, input logic [15:0] c,
                         input logic sw, input logic [7:0] st, input logic irq);
        step = s; br_valid = bv; br_target = bt; ex_cnt_we = cw; ex_cnt = c;
        ex_st_we = sw; ex_st = st; irq_req = irq;
        @(negedge clk);
        step = 1'b0; br_valid = 1'b0; ex_cnt_we = 1'b0; ex_st_we = 1'b0; irq_req = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc, 0);
        chk("R1 cnt", rpt_cnt, 0);
        chk("R1 status", status, 0);
        chk("R1 swap", sp_swap, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 20; i++) begin
            drive(TBL[i].stp, TBL[i].brv, TBL[i].brt, TBL[i].cwe, TBL[i].cv,
                  TBL[i].swe, TBL[i].sv, 1'b0);
            chk($sformatf("R2-R7 row %0d pc", i), pc, TBL[i].epc);
            chk($sformatf("R4 row %0d cnt", i), rpt_cnt, TBL[i].ecnt);
            chk($sformatf("R6 row %0d status", i), status, TBL[i].est);
        end

        // R8 debug trap at 0x100 with DB|SM and flags written by the instruction
        brk_addr = 32'h100;
        drive(1'b1, 1'b0, 32'h0, 1'b0, 16'h0, 1'b1, 8'hC5, 1'b0);
        brk_addr = 32'hFFFF_0000;
        chk("R8 pc", pc, DBGV);
        chk("R8 dbg_pc", dbg_pc, 32'h108);
        chk("R8 dbg_status", dbg_status, 8'hC7);
        chk("R8 status", status, 8'h09);
        chk("R8 cnt kept", rpt_cnt, 16'h1);

        // R9 interrupt accepted with IE set; the concurrent step is discarded
        drive(1'b1, 1'b0, 32'h0, 1'b0, 16'h0, 1'b1, 8'h11, 1'b0);
        chk("R2 pc", pc, DBGV + 32'd8);
        drive(1'b1, 1'b1, 32'h300, 1'b1, 16'h7, 1'b1, 8'hFF, 1'b1);
        chk("R9 pc", pc, IRQV);
        chk("R9 status", status, 8'h00);
        chk("R9 bkp_pc", bkp_pc, DBGV + 32'd8);
        chk("R9 bkp_status", bkp_status, 8'h11);
        chk("R9 cnt unchanged", rpt_cnt, 16'h1);
        chk("R11 swap high", sp_swap, 1);
        drive(1'b0, 1'b0, 32'h0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
        chk("R11 swap low", sp_swap, 0);

        // R10 masked request held, duplicate merged
        drive(1'b0, 1'b0, 32'h0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b1);
        chk("R10 masked pc", pc, IRQV);
        drive(1'b0, 1'b0, 32'h0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b1);
        drive(1'b1, 1'b0, 32'h0, 1'b0, 16'h0, 1'b1, 8'h10, 1'b0);
        chk("R10 no accept while masked", pc, IRQV + 32'd8);
        chk("R10 swap idle", sp_swap, 0);
        drive(1'b0, 1'b0, 32'h0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
        chk("R10 pending taken pc", pc, IRQV);
        chk("R10 bkp_pc", bkp_pc, IRQV + 32'd8);
        chk("R10 bkp_status", bkp_status, 8'h10);
        chk("R11 swap after pending", sp_swap, 1);
        drive(1'b1, 1'b0, 32'h0, 1'b0, 16'h0, 1'b1, 8'h10, 1'b0);
        drive(1'b0, 1'b0, 32'h0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
        chk("R10 duplicate dropped pc", pc, IRQV + 32'd8);
        chk("R10 duplicate dropped swap", sp_swap, 0);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pc again", pc, 0);
        chk("R1 status again", status, 0);
        chk("R1 cnt again", rpt_cnt, 0);
        chk("R1 dbg_pc", dbg_pc, 0);
        chk("R1 bkp_pc", bkp_pc, 0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 32'h0, 1'b0, 16'h0, 1'b1, 8'h10, 1'b0);
        chk("R1 no pending after reset", pc, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule